// File: doc/BRIEF.md
# Signed Single-Precision Multiply Execute Unit

This unit executes the signed 16-bit multiply instruction of a small processor core. The core's front end supplies the opcode, the low 4-bit field of the first instruction word, the following extension word when the form carries one, and the current value of the destination register (RA). It also supplies the value of the register that the low field names and, for the memory forms, the operand already fetched from memory. The unit forms the second operand from these inputs according to the addressing form. It multiplies that operand by RA and returns only the low half of the two's-complement product.

A one-cycle `start` pulse begins an operation. The unit latches every input it needs on that edge. It then runs an iterative shift-and-add multiply over the operand magnitudes, one bit per cycle, and applies the sign at the end. On completion it pulses `done` for one cycle together with a write-back strobe, the result, a one-hot condition code and an overflow interrupt request. An overflow does not stop the write-back. An instruction the unit does not recognise completes on the edge that samples `start`, raises `illegal`, and writes nothing back.

Top module: `smul_exec`

## Requirements
- R1: Opcode 0xC1 (register form) takes the operand from `rb_val`, the register named by the low field.
- R2: Opcode 0xC2 (short positive) takes the operand +N, where the low field holds N-1 (N from 1 to 16).
- R3: Opcode 0xC3 (short negative) takes the operand -N in two's complement, where the low field holds N-1.
- R4: Opcode 0xC0 (direct or indexed memory form) takes the operand from `mem_data`, whatever the low field holds.
- R5: Opcode 0x4A with low field 4 (immediate form) takes the operand from `ext_word`.
- R6: `result` equals bits 15..0 of the signed 32-bit product of RA and the operand. It is presented with `wr_en` high and `done` high.
- R7: If the operands have equal sign bits, `ovf_irq` is 1 when the product's upper 16 bits are nonzero or bit 15 of the low half is 1.
- R8: If the operands have different sign bits, `ovf_irq` is 1 when the product's upper 16 bits are not 0xFFFF or bit 15 of the low half is 0.
- R9: `ovf_irq` stays 0 whenever either operand is zero, even when the sign bits differ.
- R10: On write-back, `cond` is 4'b0010 for a zero result, 4'b0001 for a negative result and 4'b0100 for a positive result.
- R11: For a legal form, `busy` is high from the edge that samples `start` until `done` rises. `done` rises on the (DW+2)th rising edge, counting the edge that samples `start` as the first, and is high for exactly one cycle.
- R12: Any other opcode, and opcode 0x4A with a low field other than 4, completes on the edge that samples `start`. The unit then pulses `done` and `illegal` with `wr_en` and `ovf_irq` at 0, `result` equal to RA, and `cond` unchanged.
- R13: A `start` that arrives while `busy` is high is ignored. The operation in progress completes with the operands latched when it began.
- R14: After reset, `result` and `cond` are zero and `busy`, `done`, `wr_en`, `illegal` and `ovf_irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (sampled only while idle) |
| opcode | input | 8 | First byte of the instruction word |
| fld_lo | input | 4 | Low field of the instruction word |
| ext_word | input | DW | Extension word (used as data in immediate form) |
| ra_val | input | DW | Current value of RA |
| rb_val | input | DW | Value of the register named by the low field |
| mem_data | input | DW | Operand fetched from memory |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| wr_en | output | 1 | Write `result` back to RA |
| result | output | DW | Low half of the product |
| cond | output | 4 | Condition status |
| ovf_irq | output | 1 | Fixed-point overflow interrupt request |
| illegal | output | 1 | Unrecognised instruction |

## Verification
The bench builds the unit with DW=16. At that width every short-immediate value from +1 to +16 and from -1 to -16 can be driven. So can every overflow boundary: 0x7FFF times 1 and 2, -32768 times -1, and products just inside and outside the range. The exact 18-edge latency is also checked cycle by cycle. With 16 steps, a second `start` injected mid-run lands well inside the busy window, and the zero-operand exemption can be driven with a negative partner, where the opposite-sign rule alone would flag overflow.

// File: rtl/smul_pkg.sv
package smul_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} smul_state_t;

  localparam logic [7:0] OPC_REG  = 8'hC1;
  localparam logic [7:0] OPC_SPOS = 8'hC2;
  localparam logic [7:0] OPC_SNEG = 8'hC3;
  localparam logic [7:0] OPC_MEM  = 8'hC0;
  localparam logic [7:0] OPC_IMM  = 8'h4A;
  localparam logic [3:0] IMM_TAG  = 4'h4;

  localparam logic [3:0] CS_ZERO = 4'b0010;
  localparam logic [3:0] CS_NEG  = 4'b0001;
  localparam logic [3:0] CS_POS  = 4'b0100;
endpackage

// File: rtl/smul_decode.sv
module smul_decode
  import smul_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [7:0]    opcode,
  input  logic [3:0]    fld_lo,
  input  logic [DW-1:0] ext_word,
  input  logic [DW-1:0] rb_val,
  input  logic [DW-1:0] mem_data,
  output logic [DW-1:0] operand,
  output logic          legal
);
  logic [DW-1:0] short_n;

  // short forms carry N-1 in the low field
  assign short_n = DW'({1'b0, fld_lo}) + DW'(1);

  always_comb begin
    operand = '0;
    legal   = 1'b1;
    unique case (opcode)
      OPC_REG:  operand = rb_val;
      OPC_SPOS: operand = short_n;
      OPC_SNEG: operand = DW'(0) - short_n;
      OPC_MEM:  operand = mem_data;
      OPC_IMM: begin
        operand = ext_word;
        legal   = (fld_lo == IMM_TAG);
      end
      default:  legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/smul_seq_mult.sv
module smul_seq_mult #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          step,
  input  logic [DW-1:0] mag_a,
  input  logic [DW-1:0] mag_b,
  output logic [2*DW-1:0] product
);
  logic [DW-1:0] acc_hi;
  logic [DW-1:0] acc_lo;
  logic [DW-1:0] mcand;
  logic [DW:0]   sum;

  assign sum     = {1'b0, acc_hi} + (acc_lo[0] ? {1'b0, mcand} : '0);
  assign product = {acc_hi, acc_lo};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_hi <= '0;
      acc_lo <= '0;
      mcand  <= '0;
    end else if (load) begin
      acc_hi <= '0;
      acc_lo <= mag_b;
      mcand  <= mag_a;
    end else if (step) begin
      acc_hi <= sum[DW:1];
      acc_lo <= {sum[0], acc_lo[DW-1:1]};
    end
  end
endmodule

// File: rtl/smul_flags.sv
module smul_flags
  import smul_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [2*DW-1:0] mag_prod,
  input  logic            sign_diff,
  input  logic            zero_op,
  output logic [DW-1:0]   res_lo,
  output logic [3:0]      res_cond,
  output logic            res_ovf
);
  logic [2*DW-1:0] sprod;
  logic [DW-1:0]   hi;

  assign sprod  = sign_diff ? ((2*DW)'(0) - mag_prod) : mag_prod;
  assign hi     = sprod[2*DW-1:DW];
  assign res_lo = sprod[DW-1:0];

  always_comb begin
    if (zero_op)
      res_ovf = 1'b0;
    else if (sign_diff)
      res_ovf = (hi != '1) || !res_lo[DW-1];
    else
      res_ovf = (hi != '0) || res_lo[DW-1];

    if (res_lo == '0)
      res_cond = CS_ZERO;
    else if (res_lo[DW-1])
      res_cond = CS_NEG;
    else
      res_cond = CS_POS;
  end
endmodule

// File: rtl/smul_exec.sv
module smul_exec
  import smul_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [7:0]    opcode,
  input  logic [3:0]    fld_lo,
  input  logic [DW-1:0] ext_word,
  input  logic [DW-1:0] ra_val,
  input  logic [DW-1:0] rb_val,
  input  logic [DW-1:0] mem_data,
  output logic          busy,
  output logic          done,
  output logic          wr_en,
  output logic [DW-1:0] result,
  output logic [3:0]    cond,
  output logic          ovf_irq,
  output logic          illegal
);
  localparam int CW = (DW > 1) ? $clog2(DW) : 1;

  smul_state_t     state;
  logic [CW-1:0]   cnt;
  logic [DW-1:0]   operand;
  logic            legal;
  logic            accept;
  logic [DW-1:0]   mag_a, mag_b;
  logic            diff_q, zero_q;
  logic [2*DW-1:0] mag_prod;
  logic [DW-1:0]   f_lo;
  logic [3:0]      f_cond;
  logic            f_ovf;

  smul_decode #(.DW(DW)) u_dec (
    .opcode(opcode), .fld_lo(fld_lo), .ext_word(ext_word),
    .rb_val(rb_val), .mem_data(mem_data),
    .operand(operand), .legal(legal)
  );

  assign accept = (state == ST_IDLE) && start;
  assign mag_a  = ra_val[DW-1] ? (DW'(0) - ra_val) : ra_val;
  assign mag_b  = operand[DW-1] ? (DW'(0) - operand) : operand;

  smul_seq_mult #(.DW(DW)) u_mul (
    .clk(clk), .rst(rst),
    .load(accept && legal), .step(state == ST_RUN),
    .mag_a(mag_a), .mag_b(mag_b), .product(mag_prod)
  );

  smul_flags #(.DW(DW)) u_flg (
    .mag_prod(mag_prod), .sign_diff(diff_q), .zero_op(zero_q),
    .res_lo(f_lo), .res_cond(f_cond), .res_ovf(f_ovf)
  );

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      diff_q  <= 1'b0;
      zero_q  <= 1'b0;
      done    <= 1'b0;
      wr_en   <= 1'b0;
      ovf_irq <= 1'b0;
      illegal <= 1'b0;
      result  <= '0;
      cond    <= '0;
    end else begin
      done    <= 1'b0;
      wr_en   <= 1'b0;
      ovf_irq <= 1'b0;
      illegal <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          if (!legal) begin
            done    <= 1'b1;
            illegal <= 1'b1;
            result  <= ra_val;
          end else begin
            diff_q <= ra_val[DW-1] ^ operand[DW-1];
            zero_q <= (ra_val == '0) || (operand == '0);
            cnt    <= '0;
            state  <= ST_RUN;
          end
        end
        ST_RUN: begin
          cnt <= cnt + CW'(1);
          if (cnt == CW'(DW-1)) state <= ST_FIN;
        end
        ST_FIN: begin
          result  <= f_lo;
          cond    <= f_cond;
          ovf_irq <= f_ovf;
          wr_en   <= 1'b1;
          done    <= 1'b1;
          state   <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/smul_exec_chk.sv
module smul_exec_chk
  import smul_pkg::*;
#(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          done,
  input logic          wr_en,
  input logic          illegal,
  input logic          ovf_irq,
  input logic [3:0]    cond,
  input logic [DW-1:0] result
);
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_busy_excl_r11: assert property (@(posedge clk) disable iff (rst)
    busy |-> !done);
  p_illegal_nowrite_r12: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (done && !wr_en && !ovf_irq));
  p_illegal_cond_r12: assert property (@(posedge clk) disable iff (rst)
    illegal |-> $stable(cond));
  p_wr_done_r6: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> done);
  p_ovf_with_write_r8: assert property (@(posedge clk) disable iff (rst)
    ovf_irq |-> wr_en);
  p_cond_onehot_r10: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ($countones(cond) == 1));
  p_cond_zero_r10: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ((cond == CS_ZERO) == (result == '0)));
  p_cond_sign_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && result != '0) |-> (cond == (result[DW-1] ? CS_NEG : CS_POS)));
endmodule

bind smul_exec smul_exec_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .wr_en(wr_en),
  .illegal(illegal), .ovf_irq(ovf_irq), .cond(cond), .result(result)
);

// File: tb/smul_exec_bench.sv
module smul_exec_bench;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [7:0]    opcode = '0;
  logic [3:0]    fld_lo = '0;
  logic [DW-1:0] ext_word = '0, ra_val = '0, rb_val = '0, mem_data = '0;
  logic          busy, done, wr_en, ovf_irq, illegal;
  logic [DW-1:0] result;
  logic [3:0]    cond;

  int n_chk = 0;
  int n_bad = 0;
  logic [3:0] last_cond = 4'b0000;

  always #4 clk = ~clk;

  smul_exec #(.DW(DW)) u_smul_exec (
    .clk(clk), .rst(rst), .start(start), .opcode(opcode), .fld_lo(fld_lo),
    .ext_word(ext_word), .ra_val(ra_val), .rb_val(rb_val), .mem_data(mem_data),
    .busy(busy), .done(done), .wr_en(wr_en), .result(result), .cond(cond),
    .ovf_irq(ovf_irq), .illegal(illegal)
  );

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference: integer product and the sign rules
  task automatic model(input logic [15:0] a, input logic [15:0] d,
                       output logic [15:0] lo, output logic ov, output logic [3:0] cs);
    int p;
    logic [31:0] pv;
    p  = int'($signed(a)) * int'($signed(d));
    pv = p;
    lo = pv[15:0];
    if (a == 0 || d == 0) ov = 1'b0;
    else if (a[15] == d[15]) ov = (pv[31:16] != 16'h0000) || pv[15];
    else ov = (pv[31:16] != 16'hFFFF) || !pv[15];
    cs = (lo == 0) ? 4'b0010 : (lo[15] ? 4'b0001 : 4'b0100);
  endtask

  task automatic run_op(input string req, input logic [7:0] op, input logic [3:0] nib,
                        input logic [15:0] a, input logic [15:0] rb,
                        input logic [15:0] mem, input logic [15:0] ext,
                        input bit inject);
    logic [15:0] d, e_lo;
    logic e_ov, lgl;
    logic [3:0] e_cs;
    int lat;
    lgl = 1'b1;
    case (op)
      8'hC1: d = rb;
      8'hC2: d = 16'(nib) + 16'd1;
      8'hC3: d = 16'd0 - (16'(nib) + 16'd1);
      8'hC0: d = mem;
      8'h4A: begin d = ext; lgl = (nib == 4'h4); end
      default: begin d = 16'd0; lgl = 1'b0; end
    endcase
    model(a, d, e_lo, e_ov, e_cs);
    lat = lgl ? DW + 2 : 1;
    @(negedge clk);
    opcode = op; fld_lo = nib; ra_val = a; rb_val = rb; mem_data = mem; ext_word = ext;
    start = 1'b1;
    for (int k = 1; k <= lat; k++) begin
      @(negedge clk);
      if (k == 1) start = 1'b0;
      if (inject && k == 3) begin
        start = 1'b1; ra_val = ~a; rb_val = ~rb; opcode = 8'hC1;
      end
      if (inject && k == 4) start = 1'b0;
      chk(done == (k == lat), "R11", "done timing", 32'(done), 32'(k == lat));
      chk(busy == (lgl && k < lat), "R11", "busy window", 32'(busy), 32'(lgl && k < lat));
    end
    if (lgl) begin
      chk(result == e_lo, req, "result", 32'(result), 32'(e_lo));
      chk(ovf_irq == e_ov, e_ov ? "R7/R8" : "R9 (no overflow)", "ovf_irq", 32'(ovf_irq), 32'(e_ov));
      chk(cond == e_cs, "R10", "cond", 32'(cond), 32'(e_cs));
      chk(wr_en && !illegal, "R6", "wr_en/illegal", {30'd0, wr_en, illegal}, 32'h2);
      last_cond = e_cs;
    end else begin
      chk(illegal && !wr_en && !ovf_irq, "R12", "illegal flags",
          {29'd0, illegal, wr_en, ovf_irq}, 32'h4);
      chk(result == a, "R12", "result keeps RA", 32'(result), 32'(a));
      chk(cond == last_cond, "R12", "cond unchanged", 32'(cond), 32'(last_cond));
    end
    @(negedge clk);
    chk(!done && !wr_en, "R11", "done one cycle", {30'd0, done, wr_en}, 32'h0);
  endtask

  initial begin
    #800000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(result == 0 && cond == 0, "R14", "reset result/cond", {12'd0, cond, result}, 32'h0);
    chk(!busy && !done && !wr_en && !illegal && !ovf_irq, "R14", "reset flags",
        {27'd0, busy, done, wr_en, illegal, ovf_irq}, 32'h0);

    run_op("R1", 8'hC1, 4'h5, 16'd3, 16'd4, 16'd0, 16'd0, 1'b0);        // 12
    run_op("R1", 8'hC1, 4'h2, 16'd200, 16'hFF38, 16'd0, 16'd0, 1'b0);  // -40000 overflow R8
    run_op("R2", 8'hC2, 4'h0, 16'hFFF9, 16'd0, 16'd0, 16'd0, 1'b0);    // -7 * 1
    run_op("R2", 8'hC2, 4'hF, 16'd100, 16'd0, 16'd0, 16'd0, 1'b0);     // 100 * 16
    run_op("R3", 8'hC3, 4'hF, 16'd5, 16'd0, 16'd0, 16'd0, 1'b0);       // 5 * -16
    run_op("R3", 8'hC3, 4'h0, 16'h8000, 16'd0, 16'd0, 16'd0, 1'b0);    // -32768 * -1: R7 overflow
    run_op("R4", 8'hC0, 4'h9, 16'd300, 16'd0, 16'd300, 16'h1234, 1'b0); // 90000 overflow R7
    run_op("R5", 8'h4A, 4'h4, 16'hFFFB, 16'd0, 16'd0, 16'd0, 1'b0);    // zero operand R9
    run_op("R9", 8'hC0, 4'h0, 16'hFFFF, 16'd0, 16'd0, 16'd0, 1'b0);    // -1 * 0
    run_op("R7", 8'hC1, 4'h1, 16'h7FFF, 16'd1, 16'd0, 16'd0, 1'b0);    // no overflow
    run_op("R7", 8'hC1, 4'h1, 16'h7FFF, 16'd2, 16'd0, 16'd0, 1'b0);    // overflow
    run_op("R8", 8'hC1, 4'h1, 16'h8000, 16'd1, 16'd0, 16'd0, 1'b0);    // exact -32768
    run_op("R5", 8'h4A, 4'h4, 16'd7, 16'd0, 16'd0, 16'hFFFA, 1'b0);    // 7 * -6
    run_op("R12", 8'h4A, 4'h3, 16'h0ABC, 16'd0, 16'd0, 16'd2, 1'b0);
    run_op("R12", 8'h12, 4'h0, 16'h5555, 16'd0, 16'd0, 16'd0, 1'b0);
    run_op("R13", 8'hC1, 4'h3, 16'd1234, 16'd11, 16'd0, 16'd0, 1'b1);
    for (int i = 0; i < 40; i++) begin
      logic [15:0] ra_r, rb_r;
      ra_r = 16'($urandom);
      rb_r = (i % 3 == 0) ? 16'($urandom % 200) : 16'($urandom);
      run_op("R6", 8'hC1, 4'h0, ra_r, rb_r, 16'd0, 16'd0, 1'b0);
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule